// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block puts a small cursor image over a live video stream. The cursor image is kept in an on-chip store of 32-bit words, split into two banks. It takes the pixel column, the line number and the data-enable strobe from the display timing generator, together with the background pixel for the same position. For every pixel inside the cursor rectangle it either replaces the background with the cursor colour or alpha-blends the two. Outside the rectangle the background passes through unchanged.

Software gives a signed cursor position, the full cursor width and height, the active display size and an interlace flag. A clipping front end turns these into an on-screen origin, a visible size and an offset into the bitmap. The new geometry and the enable take effect together on the next frame-start pulse, so a cursor move never tears within a frame. A write port with an auto-incrementing pointer loads the image in row-major order.

Top module: `cursor_overlay`

## Requirements
- R1: A cursor wider than 64, taller than 64, or both wider and taller than 32 is rejected: `hw_enable` stays low. 64x32 and 32x64 are accepted.
- R2: An image word holds alpha in bits 31:24, blue in 23:16, green in 15:8 and red in 7:0. The output pixel carries red in 23:16, green in 15:8 and blue in 7:0.
- R3: A negative X (or Y) sets the screen coordinate to 0 and the bitmap offset to the magnitude of the position. The visible width (or height) shrinks by that magnitude, with a floor of 0.
- R4: If position plus size is larger than the active width (or height), the visible size becomes the active size minus the position, with a floor of 0.
- R5: With `interlaced` high, the screen Y and the visible height are halved, rounding down. Field line r of the cursor shows bitmap row (Y offset + 2r).
- R6: A visible width or height of zero, or `obj_en` low, clears `hw_enable`. While `hw_enable` is low every output pixel equals the background.
- R7: `hw_pos` packs screen Y in bits 31:16 and screen X in 15:0. `hw_size` packs visible height in 31:16 and visible width in 15:0. Both, together with `hw_enable`, change only on the clock edge that samples `frame_start` high.
- R8: An image pixel with alpha 0 passes the background unchanged in both modes.
- R9: With `blend_mode` high, each channel is out = (a'*fg + (256-a')*bg) >> 8, where a' = alpha + 1 for alpha >= 128 and a' = alpha otherwise. With `blend_mode` low, any nonzero alpha gives the cursor colour.
- R10: `wr_start` sets the write pointer to 0. Each `wr_en` stores `wr_data` at the pointer and then increments it. Addresses at or above DEPTH/2 go to the second bank. After DEPTH writes the pointer wraps to 0.
- R11: The output pixel and `out_de` follow the inputs by exactly two clock cycles. The image word used is row*width + column of the bitmap. Pixels outside the rectangle, or with `de` low, get the background.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_start | input | 1 | Reset the image write pointer |
| wr_en | input | 1 | Store one image word |
| wr_data | input | 32 | Image word, ABGR layout |
| pos_x | input | 16 | Signed cursor X |
| pos_y | input | 16 | Signed cursor Y |
| size_w | input | 7 | Full cursor width |
| size_h | input | 7 | Full cursor height |
| act_w | input | 16 | Active display width |
| act_h | input | 16 | Active display height |
| interlaced | input | 1 | Field-based vertical halving |
| obj_en | input | 1 | Cursor image present |
| frame_start | input | 1 | Frame boundary, applies new geometry |
| pix_x | input | 16 | Current pixel column |
| line_y | input | 16 | Current line |
| de | input | 1 | Data enable from timing |
| bg_pixel | input | 24 | Background RGB pixel |
| blend_mode | input | 1 | 1 blend, 0 replace |
| out_pixel | output | 24 | Composited RGB pixel |
| out_de | output | 1 | Delayed data enable |
| hw_pos | output | 32 | Applied screen position |
| hw_size | output | 32 | Applied visible size |
| hw_enable | output | 1 | Applied cursor enable |

## Verification
The hardest situation to reach is a partly off-screen cursor in interlaced mode. In that case the bitmap offset, the halved origin and the doubled row step all combine into one image address. The stimulus first loads the whole store with words whose value can be computed from their index. It then commits clipped geometries through frame-start pulses and probes single pixels at the clipped corners and edges, so any wrong address shows up as a wrong colour. A final write beyond the store depth reaches the pointer wrap, and a later probe of image index 0 shows the word that overwrote it.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int CW        = 16;   // coordinate width
    localparam int SW        = 7;    // cursor size width
    localparam int PIXW      = 24;   // RGB pixel
    localparam int WORDW     = 32;   // ABGR image word
    localparam int LONG_MAX  = 64;
    localparam int SHORT_MAX = 32;

    typedef struct packed {
        logic [CW-1:0] scr;
        logic [SW-1:0] vis;
        logic [SW-1:0] off;
    } axis_t;

    typedef struct packed {
        logic [CW-1:0] scr_x;
        logic [CW-1:0] scr_y;
        logic [SW-1:0] vis_w;
        logic [SW-1:0] vis_h;
        logic [SW-1:0] off_x;
        logic [SW-1:0] off_y;
        logic [SW-1:0] stride;
        logic          il;
        logic          en;
    } ovl_cfg_t;

    typedef struct packed {
        ovl_cfg_t        cfg;
        logic            hit1;
        logic [PIXW-1:0] bg1;
        logic            de1;
        logic            mode1;
        logic [PIXW-1:0] pix2;
        logic            de2;
    } ovl_state_t;

    // Clip one axis of the cursor against [0, lim).
    function automatic axis_t clip_axis(input logic signed [CW-1:0] p,
                                        input logic [SW-1:0] len,
                                        input logic [CW-1:0] lim);
        axis_t r;
        logic signed [CW:0] ps;
        logic [CW:0] mag;
        logic [CW:0] far;
        r   = '0;
        ps  = {p[CW-1], p};
        mag = (CW+1)'(-ps);
        far = {1'b0, p} + {{(CW+1-SW){1'b0}}, len};
        if (p[CW-1]) begin
            if (mag >= {{(CW+1-SW){1'b0}}, len}) begin
                r.off = len;
                r.vis = '0;
            end else begin
                r.off = mag[SW-1:0];
                r.vis = len - mag[SW-1:0];
            end
        end else begin
            r.scr = p;
            if (far > {1'b0, lim}) begin
                if (CW'(p) >= lim) r.vis = '0;
                else               r.vis = SW'(lim - CW'(p));
            end else begin
                r.vis = len;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/cursor_clip.sv
module cursor_clip
    import cursor_pkg::*;
(
    input  logic signed [CW-1:0] pos_x,
    input  logic signed [CW-1:0] pos_y,
    input  logic [SW-1:0]        size_w,
    input  logic [SW-1:0]        size_h,
    input  logic [CW-1:0]        act_w,
    input  logic [CW-1:0]        act_h,
    input  logic                 interlaced,
    input  logic                 obj_en,
    output ovl_cfg_t             cfg
);
    axis_t ax, ay;
    logic  size_ok;

    always_comb begin
        ax = clip_axis(pos_x, size_w, act_w);
        ay = clip_axis(pos_y, size_h, act_h);
        size_ok = !((size_w > SW'(LONG_MAX)) || (size_h > SW'(LONG_MAX)) ||
                    ((size_w > SW'(SHORT_MAX)) && (size_h > SW'(SHORT_MAX))));
        cfg        = '0;
        cfg.scr_x  = ax.scr;
        cfg.vis_w  = ax.vis;
        cfg.off_x  = ax.off;
        cfg.off_y  = ay.off;
        cfg.scr_y  = interlaced ? (ay.scr >> 1) : ay.scr;
        cfg.vis_h  = interlaced ? (ay.vis >> 1) : ay.vis;
        cfg.stride = size_w;
        cfg.il     = interlaced;
        cfg.en     = obj_en && size_ok && (cfg.vis_w != '0) && (cfg.vis_h != '0);
    end
endmodule

// File: rtl/cursor_store.sv
module cursor_store
    import cursor_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              wr_en,
    input  logic [WORDW-1:0]  wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WORDW-1:0]  rd_data
);
    localparam int AW   = $clog2(DEPTH);
    localparam int HALF = DEPTH / 2;
    localparam int HAW  = AW - 1;

    logic [AW-1:0] ptr_q, ptr_d, waddr;
    logic          sel_q;

    always_comb begin
        waddr = wr_start ? '0 : ptr_q;
        ptr_d = waddr + AW'(wr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sel_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            sel_q <= rd_addr[AW-1];
        end
    end

    for (genvar b = 0; b < 2; b++) begin : gen_bank
        logic [WORDW-1:0] mem [HALF];
        logic [WORDW-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (wr_en && (waddr[AW-1] == 1'(b)))
                mem[waddr[HAW-1:0]] <= wr_data;
            rd_q <= mem[rd_addr[HAW-1:0]];
        end
    end

    assign rd_data = sel_q ? gen_bank[1].rd_q : gen_bank[0].rd_q;
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
(
    input  logic [WORDW-1:0] fg_word,
    input  logic [PIXW-1:0]  bg_pix,
    input  logic             blend_on,
    input  logic             hit,
    output logic [PIXW-1:0]  pix_out
);
    logic [7:0] alpha;
    logic [8:0] aw;

    assign alpha = fg_word[31:24];
    assign aw    = {1'b0, alpha} + 9'(alpha[7]);

    // out byte c takes image byte (2-c): red low in word, high on output
    for (genvar c = 0; c < 3; c++) begin : gen_chan
        logic [7:0]  fg_c, bg_c;
        logic [15:0] acc;
        assign fg_c = fg_word[8*(2-c) +: 8];
        assign bg_c = bg_pix[8*c +: 8];
        assign acc  = 16'(aw) * 16'(fg_c) + 16'(9'd256 - aw) * 16'(bg_c);
        assign pix_out[8*c +: 8] = (!hit || alpha == 8'd0) ? bg_c :
                                   (!blend_on)             ? fg_c : acc[15:8];
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_start,
    input  logic                 wr_en,
    input  logic [WORDW-1:0]     wr_data,
    input  logic signed [CW-1:0] pos_x,
    input  logic signed [CW-1:0] pos_y,
    input  logic [SW-1:0]        size_w,
    input  logic [SW-1:0]        size_h,
    input  logic [CW-1:0]        act_w,
    input  logic [CW-1:0]        act_h,
    input  logic                 interlaced,
    input  logic                 obj_en,
    input  logic                 frame_start,
    input  logic [CW-1:0]        pix_x,
    input  logic [CW-1:0]        line_y,
    input  logic                 de,
    input  logic [PIXW-1:0]      bg_pixel,
    input  logic                 blend_mode,
    output logic [PIXW-1:0]      out_pixel,
    output logic                 out_de,
    output logic [2*CW-1:0]      hw_pos,
    output logic [2*CW-1:0]      hw_size,
    output logic                 hw_enable
);
    localparam int AW = $clog2(DEPTH);

    ovl_state_t       q, d;
    ovl_cfg_t         cfg_new;
    logic [AW-1:0]    rd_addr;
    logic [WORDW-1:0] rd_word;
    logic [PIXW-1:0]  mix_pix;
    logic [CW:0]      dx, dy;
    logic [CW-1:0]    row;
    logic             in_x, in_y;

    cursor_clip u_clip (
        .pos_x(pos_x), .pos_y(pos_y), .size_w(size_w), .size_h(size_h),
        .act_w(act_w), .act_h(act_h), .interlaced(interlaced),
        .obj_en(obj_en), .cfg(cfg_new)
    );

    cursor_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_en(wr_en),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_word)
    );

    cursor_mix u_mix (
        .fg_word(rd_word), .bg_pix(q.bg1), .blend_on(q.mode1),
        .hit(q.hit1), .pix_out(mix_pix)
    );

    always_comb begin
        d = q;
        if (frame_start) d.cfg = cfg_new;
        dx   = {1'b0, pix_x}  - {1'b0, q.cfg.scr_x};
        dy   = {1'b0, line_y} - {1'b0, q.cfg.scr_y};
        in_x = !dx[CW] && (dx[CW-1:0] < CW'(q.cfg.vis_w));
        in_y = !dy[CW] && (dy[CW-1:0] < CW'(q.cfg.vis_h));
        row  = CW'(q.cfg.off_y) + (q.cfg.il ? {dy[CW-2:0], 1'b0} : dy[CW-1:0]);
        rd_addr = AW'(row * CW'(q.cfg.stride) + CW'(q.cfg.off_x) + dx[CW-1:0]);
        d.hit1  = q.cfg.en && de && in_x && in_y;
        d.bg1   = bg_pixel;
        d.de1   = de;
        d.mode1 = blend_mode;
        d.pix2  = mix_pix;
        d.de2   = q.de1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_pixel = q.pix2;
    assign out_de    = q.de2;
    assign hw_pos    = {q.cfg.scr_y, q.cfg.scr_x};
    assign hw_size   = {(CW-SW)'(0), q.cfg.vis_h, (CW-SW)'(0), q.cfg.vis_w};
    assign hw_enable = q.cfg.en;

    p_hold_between_frames_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(hw_pos) && $stable(hw_size) && $stable(hw_enable));

    p_size_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hw_enable |-> (hw_size[15:0] <= 16'd64) && (hw_size[31:16] <= 16'd64) &&
                      !((hw_size[15:0] > 16'd32) && (hw_size[31:16] > 16'd32)));

    p_enabled_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_enable |-> (hw_size[15:0] != 16'd0) && (hw_size[31:16] != 16'd0));

    p_miss_passes_bg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !q.hit1 |=> out_pixel == $past(q.bg1));
endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 2048;

    typedef struct packed {
        logic signed [15:0] px;
        logic signed [15:0] py;
        logic [6:0]  w;
        logic [6:0]  h;
        logic        il;
        logic        en;
        logic [31:0] epos;
        logic [31:0] esize;
        logic        een;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{16'sd10,  16'sd20,  7'd16, 7'd8,  1'b0, 1'b1, 32'h0014_000A, 32'h0008_0010, 1'b1, 4'd7},  // R7 plain
        '{-16'sd3,  -16'sd2,  7'd16, 7'd8,  1'b0, 1'b1, 32'h0000_0000, 32'h0006_000D, 1'b1, 4'd3},  // R3
        '{16'sd630, 16'sd475, 7'd16, 7'd8,  1'b0, 1'b1, 32'h01DB_0276, 32'h0005_000A, 1'b1, 4'd4},  // R4
        '{16'sd100, 16'sd50,  7'd8,  7'd10, 1'b1, 1'b1, 32'h0019_0064, 32'h0005_0008, 1'b1, 4'd5},  // R5
        '{-16'sd20, 16'sd0,   7'd16, 7'd8,  1'b0, 1'b1, 32'h0000_0000, 32'h0008_0000, 1'b0, 4'd6},  // R6
        '{16'sd700, 16'sd0,   7'd16, 7'd8,  1'b0, 1'b1, 32'h0000_02BC, 32'h0008_0000, 1'b0, 4'd6},  // R6/R4
        '{16'sd0,   16'sd0,   7'd65, 7'd1,  1'b0, 1'b1, 32'h0000_0000, 32'h0001_0041, 1'b0, 4'd1},  // R1
        '{16'sd0,   16'sd0,   7'd33, 7'd33, 1'b0, 1'b1, 32'h0000_0000, 32'h0021_0021, 1'b0, 4'd1},  // R1
        '{16'sd0,   16'sd0,   7'd64, 7'd32, 1'b0, 1'b1, 32'h0000_0000, 32'h0020_0040, 1'b1, 4'd1},  // R1
        '{16'sd0,   16'sd0,   7'd32, 7'd64, 1'b0, 1'b1, 32'h0000_0000, 32'h0040_0020, 1'b1, 4'd1},  // R1
        '{16'sd10,  16'sd20,  7'd16, 7'd8,  1'b0, 1'b0, 32'h0014_000A, 32'h0008_0010, 1'b0, 4'd6},  // R6 obj_en
        '{16'sd5,   -16'sd3,  7'd4,  7'd10, 1'b1, 1'b1, 32'h0000_0005, 32'h0003_0004, 1'b1, 4'd5}   // R5 with R3
    };

    logic clk = 0, rst_n = 0;
    logic wr_start = 0, wr_en = 0;
    logic [31:0] wr_data = 0;
    logic signed [15:0] pos_x = 0, pos_y = 0;
    logic [6:0] size_w = 0, size_h = 0;
    logic [15:0] act_w = 16'd640, act_h = 16'd480;
    logic interlaced = 0, obj_en = 0, frame_start = 0;
    logic [15:0] pix_x = 0, line_y = 0;
    logic de = 0, blend_mode = 0;
    logic [23:0] bg_pixel = 0;
    logic [23:0] out_pixel;
    logic out_de, hw_enable;
    logic [31:0] hw_pos, hw_size;

    int checks = 0, errors = 0;
    bit wrapped = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cursor_overlay #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_en(wr_en), .wr_data(wr_data),
        .pos_x(pos_x), .pos_y(pos_y), .size_w(size_w), .size_h(size_h),
        .act_w(act_w), .act_h(act_h), .interlaced(interlaced), .obj_en(obj_en),
        .frame_start(frame_start), .pix_x(pix_x), .line_y(line_y), .de(de),
        .bg_pixel(bg_pixel), .blend_mode(blend_mode), .out_pixel(out_pixel),
        .out_de(out_de), .hw_pos(hw_pos), .hw_size(hw_size), .hw_enable(hw_enable)
    );

    function automatic logic [31:0] pat(input int k);
        logic [7:0] a;
        logic [10:0] kk;
        kk = 11'(k);
        if (kk[1:0] == 2'd0)      a = 8'h00;
        else if (kk[1:0] == 2'd1) a = 8'hFF;
        else                      a = kk[9:2] ^ 8'h3C;
        return {a, ~kk[7:0], kk[10:3], kk[7:0]};
    endfunction

    function automatic logic [31:0] word_at(input int k);
        if (wrapped && k == 0) return 32'hFF12_3456;
        return pat(k);
    endfunction

    // expected composite from R2/R8/R9
    function automatic logic [23:0] ref_pix(input logic [31:0] w, input logic [23:0] bg, input logic mode);
        int a, aw, fg[3], bc[3];
        logic [23:0] r;
        a  = int'(w[31:24]);
        aw = (a >= 128) ? a + 1 : a;
        fg[2] = int'(w[7:0]); fg[1] = int'(w[15:8]); fg[0] = int'(w[23:16]);
        bc[2] = int'(bg[23:16]); bc[1] = int'(bg[15:8]); bc[0] = int'(bg[7:0]);
        for (int c = 0; c < 3; c++) begin
            int v;
            if (a == 0)     v = bc[c];
            else if (!mode) v = fg[c];
            else            v = (aw * fg[c] + (256 - aw) * bc[c]) / 256;
            r[8*c +: 8] = 8'(v);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic commit(input logic signed [15:0] x, input logic signed [15:0] y,
                          input logic [6:0] w, input logic [6:0] h, input logic il, input logic en);
        @(negedge clk);
        pos_x = x; pos_y = y; size_w = w; size_h = h; interlaced = il; obj_en = en;
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
    endtask

    task automatic probe(input string tag, input int x, input int y, input logic mode,
                         input logic [23:0] bgv, input bit hit, input int idx, input logic dval);
        logic [23:0] exp;
        @(negedge clk);
        pix_x = 16'(x); line_y = 16'(y); de = dval; blend_mode = mode; bg_pixel = bgv;
        @(negedge clk);
        de = 0;
        @(negedge clk);
        exp = (hit && dval) ? ref_pix(word_at(idx), bgv, mode) : bgv;
        check(tag, {8'h0, out_pixel}, {8'h0, exp});
        check({tag, " de"}, {31'h0, out_de}, {31'h0, dval});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check("R11 reset out_pixel", {8'h0, out_pixel}, 32'h0);
        check("R6 reset hw_enable", {31'h0, hw_enable}, 32'h0);
        check("R7 reset hw_pos", hw_pos, 32'h0);
        check("R11 reset out_de", {31'h0, out_de}, 32'h0);

        // R10: load the whole store, linear order
        wr_start = 1;
        @(negedge clk);
        wr_start = 0;
        for (int k = 0; k < DEPTH; k++) begin
            wr_en = 1; wr_data = pat(k);
            @(negedge clk);
        end
        wr_en = 0;

        // geometry table
        for (int i = 0; i < 12; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            commit(VECS[i].px, VECS[i].py, VECS[i].w, VECS[i].h, VECS[i].il, VECS[i].en);
            check({t, " pos"},  hw_pos,  VECS[i].epos);
            check({t, " size"}, hw_size, VECS[i].esize);
            check({t, " en"},   {31'h0, hw_enable}, {31'h0, VECS[i].een});
        end

        // R6: disabled cursor leaves pixels alone (last vec enabled; use obj_en low)
        commit(16'sd0, 16'sd0, 7'd16, 7'd8, 1'b0, 1'b0);
        probe("R6 disabled pixel", 2, 2, 1'b0, 24'h0A0B0C, 0, 0, 1'b1);

        // R3: top-left clipped: off (3,2), vis 13x6
        commit(-16'sd3, -16'sd2, 7'd16, 7'd8, 1'b0, 1'b1);
        probe("R3 corner", 0, 0, 1'b0, 24'h102030, 1, 35, 1'b1);
        probe("R3 far corner", 12, 5, 1'b0, 24'h102030, 1, 127, 1'b1);
        probe("R3 right of vis", 13, 0, 1'b0, 24'h102030, 0, 0, 1'b1);
        probe("R3 below vis", 0, 6, 1'b0, 24'h102030, 0, 0, 1'b1);

        // R7: geometry does not move without frame_start
        @(negedge clk);
        pos_x = 16'sd200; pos_y = 16'sd100;
        @(negedge clk);
        check("R7 no frame hold pos", hw_pos, 32'h0000_0000);
        check("R7 no frame hold size", hw_size, 32'h0006_000D);

        // R4: right/bottom clip, last visible pixel
        commit(16'sd630, 16'sd475, 7'd16, 7'd8, 1'b0, 1'b1);
        probe("R4 edge pixel", 639, 479, 1'b0, 24'h000000, 1, 73, 1'b1);

        // R5: interlaced, origin y 25, rows step by 2
        commit(16'sd100, 16'sd50, 7'd8, 7'd10, 1'b1, 1'b1);
        probe("R5 field line", 103, 27, 1'b0, 24'h445566, 1, 35, 1'b1);
        probe("R5 past half height", 103, 30, 1'b0, 24'h445566, 0, 0, 1'b1);
        probe("R5 left of origin", 99, 25, 1'b0, 24'h445566, 0, 0, 1'b1);

        // R10/R2/R8/R9 on full 64x32 cursor, second bank
        commit(16'sd0, 16'sd0, 7'd64, 7'd32, 1'b0, 1'b1);
        probe("R10 bank1 replace", 5, 20, 1'b0, 24'h112233, 1, 1285, 1'b1);
        probe("R9 blend mid alpha", 6, 20, 1'b1, 24'h80C040, 1, 1286, 1'b1);
        probe("R8 alpha zero blend", 4, 20, 1'b1, 24'h99AABB, 1, 1284, 1'b1);
        probe("R8 alpha zero replace", 4, 20, 1'b0, 24'h99AABB, 1, 1284, 1'b1);
        probe("R9 alpha full blend", 1, 0, 1'b1, 24'h77EE11, 1, 1, 1'b1);
        probe("R11 de low in rect", 5, 20, 1'b0, 24'h123456, 1, 1285, 1'b0);

        // R10 wrap: one more write lands on index 0; R2 byte order
        @(negedge clk);
        wr_en = 1; wr_data = 32'hFF12_3456;
        @(negedge clk);
        wr_en = 0;
        wrapped = 1;
        commit(16'sd0, 16'sd0, 7'd16, 7'd8, 1'b0, 1'b1);
        probe("R10 wrap overwrite", 0, 0, 1'b0, 24'h000000, 1, 0, 1'b1);
        check("R2 channel order", {8'h0, out_pixel}, 32'h0056_3412);

        done = 1;
        finish_run();
    end
endmodule